// File: doc/BRIEF.md
# Parallel Two-Bit Sample Requantizer

This block reduces signed 8-bit converter samples to 2-bit symbols. A single fabric clock has to carry a sample stream four times faster than itself, so each channel delivers four samples per clock on one 32-bit word. All four lanes of a channel are compared in parallel against that channel's signed low and high decision levels. There are two channels by default, and each has its own pair of levels.

The decision levels are held in a packed configuration word inside the block. Software can rewrite the whole word in one write. It can also write a single magnitude for one channel, which sets that channel's pair symmetrically around zero. The comparators never see the configuration word directly. A small two-state controller copies it into a local resampled register, and only that copy feeds the compare stage. The controller has two states. ST_HOLD keeps the copy unchanged. ST_LOAD refreshes the copy on the next clock. Any accepted write moves the controller from ST_HOLD to ST_LOAD. ST_LOAD stays in ST_LOAD while writes keep arriving and returns to ST_HOLD otherwise. Because all lanes read the same copy, a new setting always takes effect for every lane on the same clock.

Top module: `rq_requant_top`

## Requirements
- R1: During and after reset, `out_valid` is 0 and `out_symbols` is 0. Both channels start with a low level of -32 and a high level of +32.
- R2: For sample s with low level lo and high level hi, all signed, the symbol is 2'b11 if s >= hi. Otherwise it is 2'b00 if s <= lo. Otherwise it is 2'b01 if s < 0. Otherwise it is 2'b10. The tests are checked in that order.
- R3: Sample lane l of channel c is `in_samples[c*32 + l*8 +: 8]`, with lane 0 the earliest. Its symbol appears on `out_symbols[c*8 + l*2 +: 2]`.
- R4: An input presented on `in_valid` before clock edge k appears on the outputs after edge k+1, and `out_valid` repeats `in_valid` with the same two-clock delay.
- R5: A `cfg_wr` loads `cfg_data` as the packed levels. Bits [7:0] hold the channel 0 low level, [15:8] the channel 0 high level, [23:16] the channel 1 low level and [31:24] the channel 1 high level, all two's complement.
- R6: A `lvl_wr` with magnitude L sets the selected channel's low level to -L and its high level to +L. The other channel is left as it was.
- R7: A `lvl_wr` whose `lvl_val` is below 2 or above 126 changes nothing.
- R8: When `cfg_wr` and `lvl_wr` are asserted together, only the full-word write takes effect.
- R9: A write accepted at a clock edge applies to all four lanes of both channels. Samples presented in the same cycle as the write use the old levels, and samples presented in the next cycle use the new levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_samples | input | 64 | Four signed samples per channel, channel 0 in the low half |
| cfg_wr | input | 1 | Full packed-level write strobe |
| cfg_data | input | 32 | Packed levels for a full write |
| lvl_wr | input | 1 | Symmetric magnitude write strobe |
| lvl_ch | input | 1 | Channel selected by a magnitude write |
| lvl_val | input | 7 | Magnitude for a symmetric write |
| out_valid | output | 1 | Output word qualifier |
| out_symbols | output | 16 | Four 2-bit symbols per channel, channel 0 in the low byte |

## Verification
The hardest case to reach from the ports is a level change that lands inside an unbroken run of valid words. In that case the resampled copy and the configuration word disagree for exactly one clock, and a wrong cut-over would show up on one word only. The stimulus streams valid samples that sit on both the old and the new decision levels, and it issues writes in the middle of the stream, including back-to-back writes and a full write combined with a magnitude write. A cycle-accurate reference model then predicts for each output word which levels it must have used.

// File: rtl/rq_pkg.sv
package rq_pkg;

    // Controller states for the resampled level register
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_LOAD = 1'b1
    } thr_state_e;

    // Symbol codes
    localparam logic [1:0] SYM_FLOOR = 2'b00;
    localparam logic [1:0] SYM_NEG   = 2'b01;
    localparam logic [1:0] SYM_POS   = 2'b10;
    localparam logic [1:0] SYM_CEIL  = 2'b11;

endpackage

// File: rtl/rq_cfg_reg.sv
module rq_cfg_reg #(
    parameter int NUM_CH  = 2,
    parameter int SW      = 8,
    parameter int LVL_W   = 7,
    parameter int LVL_MIN = 2,
    parameter int LVL_MAX = 126,
    parameter int DEF_LVL = 32,
    localparam int CFG_W  = NUM_CH * 2 * SW,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             lvl_wr,
    input  logic [CH_W-1:0]  lvl_ch,
    input  logic [LVL_W-1:0] lvl_val,
    output logic [CFG_W-1:0] cfg_q,
    output logic             upd_o
);

    localparam logic [SW-1:0]    DEF_HI  = SW'(DEF_LVL);
    localparam logic [SW-1:0]    DEF_LO  = SW'(-DEF_LVL);
    localparam logic [CFG_W-1:0] RST_VAL = {NUM_CH{DEF_HI, DEF_LO}};
    localparam logic [LVL_W-1:0] LMIN    = LVL_W'(LVL_MIN);
    localparam logic [LVL_W-1:0] LMAX    = LVL_W'(LVL_MAX);
    localparam logic [CH_W:0]    CH_LIM  = (CH_W+1)'(NUM_CH);

    logic             lvl_ok;
    logic [SW-1:0]    lvl_hi;
    logic [SW-1:0]    lvl_lo;
    logic [CFG_W-1:0] cfg_d;

    always_comb begin
        lvl_ok = lvl_wr && (lvl_val >= LMIN) && (lvl_val <= LMAX)
                 && ({1'b0, lvl_ch} < CH_LIM);
        lvl_hi = SW'(lvl_val);
        lvl_lo = SW'(0) - lvl_hi;
    end

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d = cfg_data;
        end else if (lvl_ok) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (lvl_ch == CH_W'(c)) begin
                    cfg_d[c*2*SW +: SW]      = lvl_lo;
                    cfg_d[c*2*SW + SW +: SW] = lvl_hi;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign upd_o = cfg_wr | lvl_ok;

    // R8
    cfg_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q == $past(cfg_data)));

    // R7
    lvl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_wr && !cfg_wr && ((lvl_val < LMIN) || (lvl_val > LMAX)))
        |=> $stable(cfg_q));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl_chk
        // R6
        lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_wr && !cfg_wr && (lvl_val >= LMIN) && (lvl_val <= LMAX)
             && (lvl_ch == CH_W'(c)))
            |=> (((cfg_q[c*2*SW + SW +: SW] + cfg_q[c*2*SW +: SW]) == '0)
                 && (cfg_q[c*2*SW + SW +: LVL_W] == $past(lvl_val))));
    end

endmodule

// File: rtl/rq_thr_sync.sv
module rq_thr_sync
    import rq_pkg::*;
#(
    parameter int             CFG_W   = 32,
    parameter logic [CFG_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [CFG_W-1:0] act_q
);

    thr_state_e state_q;
    thr_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = upd_i ? ST_LOAD : ST_HOLD;
            ST_LOAD: state_d = upd_i ? ST_LOAD : ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // Output: resampled copy of the level word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= RST_VAL;
        end else if (state_q == ST_LOAD) begin
            act_q <= cfg_i;
        end
    end

    // R9
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (act_q == $past(cfg_i)));

    // R9
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(act_q));

endmodule

// File: rtl/rq_lane.sv
module rq_lane
    import rq_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] smp_i,
    input  logic [SW-1:0] lo_i,
    input  logic [SW-1:0] hi_i,
    output logic [1:0]    sym_o
);

    logic       at_ceil;
    logic       at_floor;
    logic [1:0] sym_d;

    always_comb begin
        at_ceil  = $signed(smp_i) >= $signed(hi_i);
        at_floor = $signed(smp_i) <= $signed(lo_i);
        if (at_ceil) begin
            sym_d = SYM_CEIL;
        end else if (at_floor) begin
            sym_d = SYM_FLOOR;
        end else if (smp_i[SW-1]) begin
            sym_d = SYM_NEG;
        end else begin
            sym_d = SYM_POS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_o <= '0;
        end else begin
            sym_o <= sym_d;
        end
    end

endmodule

// File: rtl/rq_requant_top.sv
module rq_requant_top #(
    parameter int NUM_CH  = 2,
    parameter int LANES   = 4,
    parameter int SW      = 8,
    parameter int LVL_W   = 7,
    parameter int LVL_MIN = 2,
    parameter int LVL_MAX = 126,
    parameter int DEF_LVL = 32,
    localparam int IN_W   = NUM_CH * LANES * SW,
    localparam int OUT_W  = NUM_CH * LANES * 2,
    localparam int CFG_W  = NUM_CH * 2 * SW,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_samples,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             lvl_wr,
    input  logic [CH_W-1:0]  lvl_ch,
    input  logic [LVL_W-1:0] lvl_val,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_symbols
);

    localparam logic [SW-1:0]    DEF_HI  = SW'(DEF_LVL);
    localparam logic [SW-1:0]    DEF_LO  = SW'(-DEF_LVL);
    localparam logic [CFG_W-1:0] RST_VAL = {NUM_CH{DEF_HI, DEF_LO}};

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] act_q;
    logic             upd;
    logic [IN_W-1:0]  smp_s1;
    logic             vld_s1;

    rq_cfg_reg #(
        .NUM_CH  (NUM_CH),
        .SW      (SW),
        .LVL_W   (LVL_W),
        .LVL_MIN (LVL_MIN),
        .LVL_MAX (LVL_MAX),
        .DEF_LVL (DEF_LVL)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .lvl_wr   (lvl_wr),
        .lvl_ch   (lvl_ch),
        .lvl_val  (lvl_val),
        .cfg_q    (cfg_q),
        .upd_o    (upd)
    );

    rq_thr_sync #(
        .CFG_W   (CFG_W),
        .RST_VAL (RST_VAL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_i (upd),
        .cfg_i (cfg_q),
        .act_q (act_q)
    );

    // Input stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_s1 <= '0;
            vld_s1 <= 1'b0;
        end else begin
            smp_s1 <= in_samples;
            vld_s1 <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= vld_s1;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            rq_lane #(.SW(SW)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .smp_i (smp_s1[(c*LANES + l)*SW +: SW]),
                .lo_i  (act_q[c*2*SW +: SW]),
                .hi_i  (act_q[c*2*SW + SW +: SW]),
                .sym_o (out_symbols[(c*LANES + l)*2 +: 2])
            );
        end
    end

    // R4
    vld_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_s1 |=> out_valid);

    // R4
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_s1 |=> !out_valid);

endmodule

// File: tb/tb_rq_requant_top.sv
`timescale 1ns/100ps
module tb_rq_requant_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_samples;
    logic        cfg_wr;
    logic [31:0] cfg_data;
    logic        lvl_wr;
    logic [0:0]  lvl_ch;
    logic [6:0]  lvl_val;
    logic        out_valid;
    logic [15:0] out_symbols;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int lo_m [2];
    int hi_m [2];
    logic [16:0] expq [$];

    always #2.5 clk = ~clk;

    rq_requant_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_samples  (in_samples),
        .cfg_wr      (cfg_wr),
        .cfg_data    (cfg_data),
        .lvl_wr      (lvl_wr),
        .lvl_ch      (lvl_ch),
        .lvl_val     (lvl_val),
        .out_valid   (out_valid),
        .out_symbols (out_symbols)
    );

    function automatic int qz(int s, int lo, int hi);
        if (s >= hi) return 3;
        if (s <= lo) return 0;
        if (s < 0)   return 1;
        return 2;
    endfunction

    function automatic logic [63:0] pk(int a0, int a1, int a2, int a3,
                                       int b0, int b1, int b2, int b3);
        return {8'(b3), 8'(b2), 8'(b1), 8'(b0), 8'(a3), 8'(a2), 8'(a1), 8'(a0)};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit v, logic [63:0] smp,
                        bit cw, logic [31:0] cd, bit lw, bit lc, int lv);
        logic [16:0] e;
        logic [15:0] sy;
        @(negedge clk);
        if (expq.size() == 2) begin
            e = expq.pop_front();
            chk(out_valid == e[16], "R4", "out_valid", 32'(out_valid), 32'(e[16]));
            if (e[16])
                chk(out_symbols == e[15:0], tag, "out_symbols",
                    32'(out_symbols), 32'(e[15:0]));
        end
        in_valid   = v;
        in_samples = smp;
        cfg_wr     = cw;
        cfg_data   = cd;
        lvl_wr     = lw;
        lvl_ch     = lc;
        lvl_val    = 7'(lv);
        for (int c = 0; c < 2; c++)
            for (int l = 0; l < 4; l++)
                sy[c*8 + l*2 +: 2] = 2'(qz(int'($signed(smp[c*32 + l*8 +: 8])),
                                          lo_m[c], hi_m[c]));
        expq.push_back({v, sy});
        // model update: applies to inputs of the next cycle
        if (cw) begin
            lo_m[0] = int'($signed(cd[7:0]));
            hi_m[0] = int'($signed(cd[15:8]));
            lo_m[1] = int'($signed(cd[23:16]));
            hi_m[1] = int'($signed(cd[31:24]));
        end else if (lw && lv >= 2 && lv <= 126) begin
            lo_m[lc] = -lv;
            hi_m[lc] = lv;
        end
    endtask

    task automatic go(string tag, logic [63:0] smp);
        step(tag, 1'b1, smp, 1'b0, 32'h0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        lo_m[0] = -32; hi_m[0] = 32; lo_m[1] = -32; hi_m[1] = 32;
        rst_n = 1'b0; in_valid = 1'b0; in_samples = '0;
        cfg_wr = 1'b0; cfg_data = '0; lvl_wr = 1'b0; lvl_ch = '0; lvl_val = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1", "reset out_valid", 32'(out_valid), 32'h0);
        chk(out_symbols == 16'h0, "R1", "reset out_symbols", 32'(out_symbols), 32'h0);
        rst_n = 1'b1;

        // R1 / R2: default levels, boundaries
        go("R1", pk(-33, -32, -31, -1, 0, 31, 32, 127));
        go("R2", pk(-128, 127, 0, -1, 33, -33, 1, -2));
        // R3: lane order, distinct symbols per lane
        go("R3", pk(-100, -5, 5, 100, 100, 5, -5, -100));
        go("R3", pk(50, -50, 10, -10, -10, 10, -50, 50));
        // R4: gap in valid
        step("R4", 1'b0, pk(1, 2, 3, 4, 5, 6, 7, 8), 1'b0, 32'h0, 1'b0, 1'b0, 0);
        go("R4", pk(-64, 64, -1, 0, 0, -1, 64, -64));
        step("R4", 1'b0, '0, 1'b0, 32'h0, 1'b0, 1'b0, 0);

        // R6: symmetric writes, other channel untouched
        step("R6", 1'b1, pk(-3, -2, -1, 2, -33, -32, 31, 32), 1'b0, 32'h0, 1'b1, 1'b0, 2);
        go("R6", pk(-3, -2, -1, 2, -33, -32, 31, 32));
        go("R6", pk(1, 0, -1, 3, 0, -1, 33, -31));
        step("R6", 1'b1, pk(-2, 2, 0, 1, -127, -126, 125, 126), 1'b0, 32'h0, 1'b1, 1'b1, 126);
        go("R6", pk(-2, 2, 0, 1, -127, -126, 125, 126));
        go("R6", pk(-128, 127, -1, 0, -125, 127, -128, 0));

        // R7: out-of-range magnitudes ignored
        step("R7", 1'b0, '0, 1'b0, 32'h0, 1'b1, 1'b0, 1);
        step("R7", 1'b0, '0, 1'b0, 32'h0, 1'b1, 1'b1, 127);
        step("R7", 1'b0, '0, 1'b0, 32'h0, 1'b1, 1'b0, 0);
        go("R7", pk(-2, -1, 1, 2, -126, -1, 1, 126));
        go("R7", pk(-3, 3, 0, -1, -127, 127, 125, -125));

        // R5: full packed write, asymmetric and inverted levels
        step("R5", 1'b0, '0, 1'b1, 32'hFB05_32F6, 1'b0, 1'b0, 0);
        go("R5", pk(-11, -10, -9, 49, -6, -5, 5, 6));
        go("R5", pk(50, 51, 0, -1, 0, 4, -4, -100));
        // R2 priority with inverted channel 1 levels
        go("R2", pk(-10, 50, -1, 0, 3, -3, 100, -128));

        // R8: simultaneous writes, full word wins
        step("R8", 1'b0, '0, 1'b1, 32'h40C0_10F0, 1'b1, 1'b0, 100);
        go("R8", pk(-16, -15, 15, 16, -64, -63, 63, 64));
        go("R8", pk(-100, 99, 100, -99, -1, 0, 1, -65));

        // R9: writes inside an unbroken valid stream
        go("R9", pk(-20, -10, 10, 20, -20, -10, 10, 20));
        step("R9", 1'b1, pk(-20, -10, 10, 20, -20, -10, 10, 20), 1'b0, 32'h0, 1'b1, 1'b0, 10);
        step("R9", 1'b1, pk(-20, -10, 10, 20, -20, -10, 10, 20), 1'b0, 32'h0, 1'b1, 1'b1, 20);
        step("R9", 1'b1, pk(-20, -10, 10, 20, -20, -10, 10, 20), 1'b1, 32'h0AF6_14EC, 1'b0, 1'b0, 0);
        go("R9", pk(-20, -10, 10, 20, -20, -10, 10, 20));
        go("R9", pk(-21, -11, 9, 19, -19, -9, 11, 21));

        // R3 / R9: random stream with random writes
        for (int i = 0; i < 400; i++) begin
            logic [63:0] rs;
            int r;
            rs = {$urandom(), $urandom()};
            r = int'($urandom_range(0, 15));
            step("R3", r != 0, rs, r == 1, $urandom(), r == 2 || r == 3,
                 1'($urandom()), int'($urandom_range(0, 127)));
        end

        step("R4", 1'b0, '0, 1'b0, 32'h0, 1'b0, 1'b0, 0);
        step("R4", 1'b0, '0, 1'b0, 32'h0, 1'b0, 1'b0, 0);
        step("R4", 1'b0, '0, 1'b0, 32'h0, 1'b0, 1'b0, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule